// File: doc/BRIEF.md
# 8B/10B Transmit Character Encoder

This block is the per-channel transmit encoder. On every clock it takes an 8-bit byte and three controls, and registers one 10-bit transmission character. It also keeps the running disparity that picks between the two polarities of each character. A front end decides how the byte is used. With the control select low, the byte is sent as a data character. With the control select high and the special enable low, the byte is replaced by the comma K28.5. With both high, the byte is read as a code that names a special K character.

A word-sync request takes priority over all the other controls. It starts a fixed 16-character sequence: one K28.5, then fifteen balanced data characters. Once the sequence has started, it runs to its end. The special enable is a static mode input. It is only changed while the control select is low.

Top module: `enc8b10b_tx`

## Requirements
- R1: While rst_ni is low, code_o is all zeros, rd_o is 0 (negative running disparity) and kerr_o is 0.
- R2: Each character appears on code_o one clock after its inputs are sampled. Bit 9 carries the first code bit (a) and bit 0 the last (j), so the 6-bit sub-block sits in bits 9:4 and the 4-bit sub-block in bits 3:0.
- R3: With no sync sequence active and ctrl_sel_i low, data_i (HGF in bits 7:5, EDCBA in bits 4:0) is encoded by the standard 5b/6b and 3b/4b tables. This covers the D.x.7 alternate form. Byte 0x00 at negative disparity gives 1001110100.
- R4: With ctrl_sel_i high and kspec_en_i low, data_i is ignored and K28.5 is sent: 0011111010 at negative disparity, 1100000101 at positive.
- R5: With ctrl_sel_i and kspec_en_i both high, byte 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC or 0xFC sends K28.0 to K28.7. Byte 0xF7, 0xFB, 0xFD or 0xFE sends K23.7, K27.7, K29.7 or K30.7. Each is encoded at the current disparity.
- R6: In special mode, byte 0xAC sends 0011111010 and byte 0xAD sends 1100000101, whatever the current disparity.
- R7: In special mode, any other byte sends K28.5 at the current disparity and raises kerr_o together with that character. kerr_o is 0 for every other character.
- R8: After a character with six ones rd_o is 1, after one with four ones rd_o is 0, and after a balanced character rd_o keeps its value.
- R9: When no sequence is active and sync_req_i is high, the next 16 characters are K28.5 followed by 0101010101 (byte 0x4A) at odd positions and 1010101010 (byte 0xB5) at even positions. All inputs, including sync_req_i, are ignored until the sequence ends.
- R10: If sync_req_i is still high in the cycle after the 16th character, a new sequence starts at once with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send, or special-character code |
| ctrl_sel_i | input | 1 | 0: data, 1: control character |
| kspec_en_i | input | 1 | Static enable that reads the byte as a K-character code |
| sync_req_i | input | 1 | Request for the 16-character word-sync sequence |
| code_o | output | 10 | Registered 10-bit character, bit 9 first |
| rd_o | output | 1 | Running disparity after code_o (1 = positive) |
| kerr_o | output | 1 | Undefined special code was replaced by K28.5 |

## Verification
A sweep of all 256 data bytes, run in order, hits every 5b/6b and 3b/4b entry, including the alternate D.x.7 codes. A pseudo-random data stream then reaches those entries from both disparities. Back-to-back commas alternate polarity, which shows the disparity is tracked. Repeated forced 0xAC/0xAD bytes show that the forced codes do not depend on the current disparity, and invalid special codes exercise the error flag. A single-cycle sync pulse sent with conflicting inputs shows that the sequence cannot be interrupted. A held request shows that sequences follow each other back to back. A final mixed stream checks every cycle against a behavioural model.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
  typedef struct packed {
    logic [7:0] chr;
    logic       is_k;
    logic       force_en;
    logic       force_pos;
    logic       bad_k;
  } char_sel_t;

  localparam logic [7:0] COMMA_BYTE     = 8'hBC;
  localparam logic [7:0] FORCE_POS_BYTE = 8'hAC;
  localparam logic [7:0] FORCE_NEG_BYTE = 8'hAD;
endpackage

// File: rtl/enc_ctrl_front.sv
module enc_ctrl_front
  import enc8b10b_pkg::*;
(
  input  logic [7:0] data_i,
  input  logic       ctrl_sel_i,
  input  logic       kspec_en_i,
  output char_sel_t  sel_o
);
  logic k28_grp, k_x7_grp;

  assign k28_grp  = (data_i[4:0] == 5'd28);
  assign k_x7_grp = (data_i == 8'hF7) || (data_i == 8'hFB) ||
                    (data_i == 8'hFD) || (data_i == 8'hFE);

  always_comb begin
    sel_o = '0;
    if (!ctrl_sel_i) begin
      sel_o.chr = data_i;
    end else if (!kspec_en_i) begin
      sel_o.chr  = COMMA_BYTE;
      sel_o.is_k = 1'b1;
    end else begin
      sel_o.is_k = 1'b1;
      if (data_i == FORCE_POS_BYTE) begin
        sel_o.chr       = COMMA_BYTE;
        sel_o.force_en  = 1'b1;
        sel_o.force_pos = 1'b1;
      end else if (data_i == FORCE_NEG_BYTE) begin
        sel_o.chr      = COMMA_BYTE;
        sel_o.force_en = 1'b1;
      end else if (k28_grp || k_x7_grp) begin
        sel_o.chr = data_i;
      end else begin
        // undefined special code: fall back to comma and flag it
        sel_o.chr   = COMMA_BYTE;
        sel_o.bad_k = 1'b1;
      end
    end
  end
endmodule

// File: rtl/enc_sync_seq.sv
module enc_sync_seq
  import enc8b10b_pkg::*;
#(
  parameter int         SEQ_LEN   = 16,
  parameter logic [7:0] ODD_BYTE  = 8'h4A,
  parameter logic [7:0] EVEN_BYTE = 8'hB5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_req_i,
  output logic      busy_o,
  output char_sel_t sel_o
);
  localparam int               CNT_W = $clog2(SEQ_LEN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SEQ_LEN - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;

  assign busy_o = active_q | sync_req_i;
  assign idx    = active_q ? cnt_q : '0;

  always_comb begin
    sel_o = '0;
    if (idx == '0) begin
      sel_o.chr  = COMMA_BYTE;
      sel_o.is_k = 1'b1;
    end else begin
      sel_o.chr = idx[0] ? ODD_BYTE : EVEN_BYTE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (sync_req_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
    end
  end

  // R9
  seq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == LAST) |=> !active_q);
  // R9
  seq_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && sync_req_i) |=> (active_q && cnt_q == CNT_W'(1)));
  // R9
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/enc_code_core.sv
module enc_code_core (
  input  logic [7:0] chr_i,
  input  logic       is_k_i,
  input  logic       force_en_i,
  input  logic       force_pos_i,
  input  logic       rd_i,
  output logic [9:0] code_o,
  output logic       rd_o
);
  logic [4:0] x;
  logic [2:0] y;
  logic       rd_eff, k28, unbal6, unbal4, rd_mid, alt7, k28_bal;
  logic [5:0] b6, c6;
  logic [3:0] b4, c4;

  function automatic logic [5:0] tbl6(input logic [4:0] v);
    case (v)
      5'd0:  tbl6 = 6'b100111; 5'd1:  tbl6 = 6'b011101;
      5'd2:  tbl6 = 6'b101101; 5'd3:  tbl6 = 6'b110001;
      5'd4:  tbl6 = 6'b110101; 5'd5:  tbl6 = 6'b101001;
      5'd6:  tbl6 = 6'b011001; 5'd7:  tbl6 = 6'b111000;
      5'd8:  tbl6 = 6'b111001; 5'd9:  tbl6 = 6'b100101;
      5'd10: tbl6 = 6'b010101; 5'd11: tbl6 = 6'b110100;
      5'd12: tbl6 = 6'b001101; 5'd13: tbl6 = 6'b101100;
      5'd14: tbl6 = 6'b011100; 5'd15: tbl6 = 6'b010111;
      5'd16: tbl6 = 6'b011011; 5'd17: tbl6 = 6'b100011;
      5'd18: tbl6 = 6'b010011; 5'd19: tbl6 = 6'b110010;
      5'd20: tbl6 = 6'b001011; 5'd21: tbl6 = 6'b101010;
      5'd22: tbl6 = 6'b011010; 5'd23: tbl6 = 6'b111010;
      5'd24: tbl6 = 6'b110011; 5'd25: tbl6 = 6'b100110;
      5'd26: tbl6 = 6'b010110; 5'd27: tbl6 = 6'b110110;
      5'd28: tbl6 = 6'b001110; 5'd29: tbl6 = 6'b101110;
      5'd30: tbl6 = 6'b011110; default: tbl6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] tbl4(input logic [2:0] v, input logic alt);
    case (v)
      3'd0: tbl4 = 4'b1011; 3'd1: tbl4 = 4'b1001;
      3'd2: tbl4 = 4'b0101; 3'd3: tbl4 = 4'b1100;
      3'd4: tbl4 = 4'b1101; 3'd5: tbl4 = 4'b1010;
      3'd6: tbl4 = 4'b0110; default: tbl4 = alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  assign x      = chr_i[4:0];
  assign y      = chr_i[7:5];
  assign k28    = is_k_i && (x == 5'd28);
  // forced comma: encode as if the opposite disparity were current
  assign rd_eff = force_en_i ? ~force_pos_i : rd_i;

  assign b6     = k28 ? 6'b001111 : tbl6(x);
  assign unbal6 = ($countones(b6) != 3);
  assign c6     = (rd_eff && (unbal6 || (x == 5'd7 && !k28))) ? ~b6 : b6;
  assign rd_mid = rd_eff ^ unbal6;

  assign alt7   = (y == 3'd7) &&
                  (is_k_i ||
                   (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                   ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
  assign b4      = tbl4(y, alt7);
  assign unbal4  = ($countones(b4) != 2);
  assign k28_bal = k28 && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6);
  assign c4      = (k28_bal ? !rd_mid : (rd_mid && (unbal4 || y == 3'd3))) ? ~b4 : b4;

  assign code_o = {c6, c4};
  assign rd_o   = rd_mid ^ unbal4;
endmodule

// File: rtl/enc8b10b_tx.sv
module enc8b10b_tx
  import enc8b10b_pkg::*;
#(
  parameter int         SYNC_LEN  = 16,
  parameter logic [7:0] SYNC_ODD  = 8'h4A,
  parameter logic [7:0] SYNC_EVEN = 8'hB5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic       ctrl_sel_i,
  input  logic       kspec_en_i,
  input  logic       sync_req_i,
  output logic [9:0] code_o,
  output logic       rd_o,
  output logic       kerr_o
);
  char_sel_t  front_sel, sync_sel, cur_sel;
  logic       sync_busy;
  logic [9:0] code_d;
  logic       rd_d;
  logic [9:0] code_q;
  logic       rd_q, kerr_q;

  enc_ctrl_front i_front (
    .data_i     (data_i),
    .ctrl_sel_i (ctrl_sel_i),
    .kspec_en_i (kspec_en_i),
    .sel_o      (front_sel)
  );

  enc_sync_seq #(
    .SEQ_LEN   (SYNC_LEN),
    .ODD_BYTE  (SYNC_ODD),
    .EVEN_BYTE (SYNC_EVEN)
  ) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_req_i (sync_req_i),
    .busy_o     (sync_busy),
    .sel_o      (sync_sel)
  );

  assign cur_sel = sync_busy ? sync_sel : front_sel;

  enc_code_core i_core (
    .chr_i       (cur_sel.chr),
    .is_k_i      (cur_sel.is_k),
    .force_en_i  (cur_sel.force_en),
    .force_pos_i (cur_sel.force_pos),
    .rd_i        (rd_q),
    .code_o      (code_d),
    .rd_o        (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      rd_q   <= 1'b0;
      kerr_q <= 1'b0;
    end else begin
      code_q <= code_d;
      rd_q   <= rd_d;
      kerr_q <= cur_sel.bad_k;
    end
  end

  assign code_o = code_q;
  assign rd_o   = rd_q;
  assign kerr_o = kerr_q;

  // R8
  pos_word_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(code_o) == 6) |-> rd_o);
  // R8
  neg_word_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(code_o) == 4) |-> !rd_o);
  // R8
  bal_word_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(code_o) == 5) |-> $stable(rd_o));
  // R2
  word_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != '0) |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6));
  // R7
  kerr_comma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kerr_o |-> (code_o == 10'b0011111010 || code_o == 10'b1100000101));
  // R7
  kerr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kerr_o) |-> $past(ctrl_sel_i && kspec_en_i && !sync_req_i));
endmodule

// File: tb/test_enc8b10b_tx.sv
module test_enc8b10b_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       ctrl = 1'b0, kspec = 1'b0, sync = 1'b0;
  logic [9:0] code;
  logic       rd, kerr;

  int errors = 0;
  int checks = 0;
  bit m_rd = 1'b0;
  bit done = 1'b0;
  logic [8:0] seq_q[$];
  logic [9:0] exp_last;
  logic [31:0] seed = 32'h1234_5678;

  localparam bit [5:0] T6 [32] = '{
    6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
    6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
    6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
    6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
    6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
    6'b011110, 6'b101011};
  localparam bit [3:0] N4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                                  4'b1101, 4'b1010, 4'b0110, 4'b1110};
  localparam bit [3:0] P4 [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                  4'b0010, 4'b1010, 4'b0110, 4'b0001};
  localparam bit [3:0] K28P [8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                    4'b0010, 4'b1010, 4'b0110, 4'b1000};

  enc8b10b_tx i_enc8b10b_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .data_i     (data),
    .ctrl_sel_i (ctrl),
    .kspec_en_i (kspec),
    .sync_req_i (sync),
    .code_o     (code),
    .rd_o       (rd),
    .kerr_o     (kerr)
  );

  always #5ns clk = ~clk;

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic encode(input logic [7:0] b, input bit k, input bit r0,
                        output logic [9:0] c, output bit r2);
    int x, y, n6;
    bit r1, alt;
    logic [5:0] c6;
    logic [3:0] c4;
    x = int'(b[4:0]);
    y = int'(b[7:5]);
    c6 = (k && x == 28) ? 6'b001111 : T6[x];
    n6 = $countones(c6);
    if (r0 && (n6 != 3 || (x == 7 && !(k && x == 28)))) c6 = ~c6;
    r1 = r0 ^ (n6 != 3);
    if (k && x == 28) begin
      c4 = r1 ? K28P[y] : ~K28P[y];
    end else begin
      alt = (y == 7) && (k || (!r1 && (x == 17 || x == 18 || x == 20)) ||
                         (r1 && (x == 11 || x == 13 || x == 14)));
      if (alt) c4 = r1 ? 4'b1000 : 4'b0111;
      else     c4 = r1 ? P4[y] : N4[y];
    end
    r2 = r1 ^ ($countones(c4) != 2);
    c = {c6, c4};
  endtask

  task automatic step(input logic [7:0] d, input bit c, input bit k, input bit s,
                      input string tag);
    logic [8:0] ent;
    logic [7:0] b;
    bit isk, bad, nr;
    logic [9:0] ec;
    string t;
    @(negedge clk);
    data = d; ctrl = c; kspec = k; sync = s;
    bad = 1'b0;
    t = tag;
    ec = '0;
    nr = m_rd;
    if (seq_q.size() == 0 && s) begin
      seq_q.push_back({1'b1, 8'hBC});
      for (int i = 1; i < 16; i++) seq_q.push_back({1'b0, (i % 2 == 1) ? 8'h4A : 8'hB5});
    end
    if (seq_q.size() > 0) begin
      ent = seq_q.pop_front();
      isk = ent[8];
      b = ent[7:0];
      t = "R9 R10";
      encode(b, isk, m_rd, ec, nr);
    end else if (!c) begin
      encode(d, 1'b0, m_rd, ec, nr);
    end else if (!k) begin
      encode(8'hBC, 1'b1, m_rd, ec, nr);
    end else if (d == 8'hAC) begin
      ec = 10'b0011111010; nr = 1'b1;
    end else if (d == 8'hAD) begin
      ec = 10'b1100000101; nr = 1'b0;
    end else if (d[4:0] == 5'd28 || d == 8'hF7 || d == 8'hFB || d == 8'hFD || d == 8'hFE) begin
      encode(d, 1'b1, m_rd, ec, nr);
    end else begin
      bad = 1'b1;
      encode(8'hBC, 1'b1, m_rd, ec, nr);
    end
    @(posedge clk);
    #1ns;
    check(t, code, ec);
    check("R8", {9'b0, rd}, {9'b0, nr});
    check("R7", {9'b0, kerr}, {9'b0, bad});
    m_rd = nr;
    exp_last = ec;
  endtask

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  initial begin
    #1_000_000ns;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23ns;
    // R1
    check("R1", code, 10'b0);
    check("R1", {9'b0, rd}, 10'b0);
    check("R1", {9'b0, kerr}, 10'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: commas alternate, byte ignored
    step(8'h00, 1'b1, 1'b0, 1'b0, "R4");
    check("R4", code, 10'b0011111010);
    step(8'h37, 1'b1, 1'b0, 1'b0, "R4");
    check("R4", code, 10'b1100000101);
    // R3: D0.0 at negative disparity
    step(8'h00, 1'b0, 1'b0, 1'b0, "R3");
    check("R3", code, 10'b1001110100);
    // switch static enable while ctrl is low
    step(8'h55, 1'b0, 1'b1, 1'b0, "R3");
    // R6: forced polarity regardless of current disparity
    step(8'hAC, 1'b1, 1'b1, 1'b0, "R6");
    check("R6", code, 10'b0011111010);
    step(8'hAC, 1'b1, 1'b1, 1'b0, "R6");
    check("R6", code, 10'b0011111010);
    step(8'hAD, 1'b1, 1'b1, 1'b0, "R6");
    check("R6", code, 10'b1100000101);
    step(8'hAD, 1'b1, 1'b1, 1'b0, "R6");
    check("R6", code, 10'b1100000101);
    // R7: undefined special code
    step(8'h00, 1'b1, 1'b1, 1'b0, "R7");
    check("R7", code, 10'b0011111010);
    check("R7", {9'b0, kerr}, 10'd1);
    step(8'hBD, 1'b1, 1'b1, 1'b0, "R7");
    step(8'hFF, 1'b1, 1'b1, 1'b0, "R7");

    // R5: every defined K code from both disparities
    for (int rep = 0; rep < 2; rep++) begin
      for (int j = 0; j < 8; j++) step(8'(j * 32 + 28), 1'b1, 1'b1, 1'b0, "R5");
      step(8'hF7, 1'b1, 1'b1, 1'b0, "R5");
      step(8'hFB, 1'b1, 1'b1, 1'b0, "R5");
      step(8'hFD, 1'b1, 1'b1, 1'b0, "R5");
      step(8'hFE, 1'b1, 1'b1, 1'b0, "R5");
      step(8'hBC, 1'b1, 1'b1, 1'b0, "R5");
    end

    // R2 R3: full data sweep, then random data
    step(8'h00, 1'b0, 1'b0, 1'b0, "R3");
    for (int v = 0; v < 256; v++) step(8'(v), 1'b0, 1'b0, 1'b0, "R2 R3");
    for (int v = 0; v < 300; v++) step(rnd8(), 1'b0, 1'b0, 1'b0, "R3");

    // R9: one-cycle request, conflicting inputs during the sequence
    step(8'h00, 1'b0, 1'b1, 1'b0, "R3");
    step(8'h12, 1'b1, 1'b1, 1'b1, "R9");
    check("R9", {9'b0, (code == 10'b0011111010 || code == 10'b1100000101)}, 10'd1);
    step(8'h00, 1'b1, 1'b1, 1'b0, "R9");
    check("R9", code, 10'b0101010101);
    check("R9", {9'b0, kerr}, 10'd0);
    step(8'h01, 1'b1, 1'b1, 1'b0, "R9");
    check("R9", code, 10'b1010101010);
    for (int i = 3; i < 16; i++) step(8'h00, 1'b1, 1'b1, 1'b0, "R9");
    step(8'h00, 1'b1, 1'b1, 1'b0, "R7");
    check("R7", {9'b0, kerr}, 10'd1);

    // R10: held request gives back-to-back sequences
    step(8'h00, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 16; i++) step(8'h33, 1'b0, 1'b0, 1'b1, "R10");
    step(8'h33, 1'b0, 1'b0, 1'b1, "R10");
    check("R10", {9'b0, (exp_last == 10'b0011111010 || exp_last == 10'b1100000101)}, 10'd1);
    for (int i = 1; i < 40; i++) step(8'h33, 1'b0, 1'b0, 1'b1, "R10");
    while (seq_q.size() > 0) step(8'h00, 1'b0, 1'b0, 1'b0, "R9");

    // mixed stream
    for (int m = 0; m < 400; m++) begin
      logic [7:0] r;
      r = rnd8();
      step(rnd8(), r[0] & r[1], 1'b0, (r[7:2] == 6'd0), "R3 R4");
    end
    while (seq_q.size() > 0) step(8'h00, 1'b0, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b0, 1'b1, 1'b0, "R3");
    for (int m = 0; m < 400; m++) begin
      logic [7:0] r;
      logic [7:0] d;
      r = rnd8();
      d = r[2] ? rnd8() : ((r[3] ? 8'hAC : 8'hAD) ^ (r[4] ? 8'h00 : 8'h10));
      step(d, r[0], 1'b1, (r[7:3] == 5'd0), "R5 R6 R7");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule